// File: doc/BRIEF.md
# Way-Predicting Four-Way Read Cache

This block is a read-only, four-way set-associative cache that predicts one way per address. Two address bits just above the set index name a preferred first-probe way, called the home way. A hit in the home way answers with the timing of a direct-mapped cache. A hit in any other way of the set is still served, one cycle later. The home-way bits belong to the stored tag, so no tag bits are lost by using them to pick the way.

On a miss the block sends a line request to memory and waits for the whole line. It writes the new line into its home way. If the home way held a valid line, that line moves into a second way of the same set instead of leaving the cache. The second way is an empty one if the set has one. Otherwise a per-set rotating pointer picks it, and the line already there is dropped. Three counters at the ports show how often requests hit the home way, hit another way, or miss.

Geometry: 32-bit byte addresses, 64-byte lines, 32 sets and 4 ways. Address bits [5:2] select the 32-bit word, [10:6] the set, [31:11] the tag, and [12:11] the home way.

Top module: `mcache_ctrl`

## Requirements
- R1: A synchronous active-high reset leaves req_ready high, resp_valid and refill_req_valid low, all counters zero, and every line invalid, so the first access to any address misses.
- R2: A request accepted while its line sits in the home way (way number = addr[12:11]) gives resp_valid exactly one cycle after acceptance. req_ready stays high, so home-way hits can follow back to back.
- R3: A request whose line sits in a way other than its home way gives resp_valid exactly two cycles after acceptance.
- R4: On a miss, refill_req_valid is high for exactly one cycle, two cycles after acceptance, with refill_addr equal to the request address with bits [5:0] cleared.
- R5: The cycle that samples refill_valid high installs the line. resp_valid follows two cycles later, carrying word addr[5:2] of refill_line (bits 32*k+31 down to 32*k for word k). The line then sits in its home way.
- R6: When a fill finds a valid line in its home way, that line moves to another way of the same set and still hits there (two-cycle response).
- R7: For the moved line, the block uses the lowest-numbered invalid way other than the home way if there is one.
- R8: If all ways of the set are valid, the moved line goes to the way named by a per-set pointer. The pointer starts at way 0 after reset, skips the home way, and steps to the next way after each use. The line that was in that way leaves the cache.
- R9: req_ready is low from the cycle after accepting a request that is not a home-way hit until its response cycle.
- R10: cnt_major_hit, cnt_other_hit and cnt_miss each count by one per home-way hit, other-way hit and miss respectively.
- R11: Sets are independent, and a line whose home way is not 0 is filled into and hit in that way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | 32 | Byte address of the request |
| req_ready | output | 1 | Block can accept a request this cycle |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_data | output | 32 | Requested word, valid with resp_valid |
| refill_req_valid | output | 1 | One-cycle line request to memory |
| refill_addr | output | 32 | Line-aligned address of the line request |
| refill_valid | input | 1 | Memory presents the requested line |
| refill_line | input | 512 | Full line from memory, word 0 in the low bits |
| cnt_major_hit | output | 16 | Count of home-way hits |
| cnt_other_hit | output | 16 | Count of hits in other ways |
| cnt_miss | output | 16 | Count of misses |

## Verification
The hardest state to reach from the ports is a set with all four ways valid and the rotating pointer at a known place. Only then does a fill drop a line, and which line it drops shows the pointer behaviour. The stimulus builds this state on purpose. It sends five addresses that share one set and one home way, so each miss pushes the previous home-way line into the next empty way. Once the set is full, later misses drop particular lines. The bench then re-reads every line. Each one must answer after two cycles or miss again, and that pattern reveals where the moved lines went and which lines left the cache.

// File: rtl/mcache_pkg.sv
package mcache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_WAIT   = 2'd2,
    ST_FILL   = 2'd3
  } mc_state_e;
endpackage

// File: rtl/mcache_way_ram.sv
// One way of line storage: a simple dual-port array with registered read,
// written so that it maps onto block RAM.
module mcache_way_ram #(
  parameter int SETS   = 32,
  parameter int LINE_W = 512,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] wr_line,
  output logic [LINE_W-1:0] rd_line
);
  logic [LINE_W-1:0] mem [SETS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_line;
    if (rd_en) rd_line <= mem[rd_idx];
  end
endmodule

// File: rtl/mcache_tag_store.sv
// Tags and valid bits for all ways, read combinationally for one set.
module mcache_tag_store #(
  parameter int WAYS  = 4,
  parameter int SETS  = 32,
  parameter int TAG_W = 21,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [IDX_W-1:0]            lk_idx,
  output logic [WAYS-1:0][TAG_W-1:0]  lk_tag,
  output logic [WAYS-1:0]             lk_vld,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [WAYS-1:0]             wr_en,
  input  logic [WAYS-1:0][TAG_W-1:0]  wr_tag
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tag_mem [SETS];
    logic [SETS-1:0]  vld_q;

    always_ff @(posedge clk) begin
      if (rst) vld_q <= '0;
      else if (wr_en[w]) vld_q[wr_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (wr_en[w]) tag_mem[wr_idx] <= wr_tag[w];
    end

    assign lk_tag[w] = tag_mem[lk_idx];
    assign lk_vld[w] = vld_q[lk_idx];
  end
endmodule

// File: rtl/mcache_victim_sel.sv
// Picks the way that receives a line pushed out of its home way:
// lowest invalid non-home way first, else a per-set rotating pointer.
module mcache_victim_sel #(
  parameter int WAYS = 4,
  parameter int SETS = 32,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic [WAY_W-1:0] home,
  input  logic [WAYS-1:0]  vld,
  input  logic             advance,
  output logic [WAY_W-1:0] victim
);
  logic [WAY_W-1:0] ptr_q [SETS];
  logic             found;
  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] rr_way;

  always_comb begin
    found    = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld[w] && (WAY_W'(w) != home)) begin
        found    = 1'b1;
        free_way = WAY_W'(w);
      end
    end
    rr_way = ptr_q[idx];
    if (rr_way == home) rr_way = rr_way + WAY_W'(1);
    victim = found ? free_way : rr_way;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
    end else if (advance && !found) begin
      ptr_q[idx] <= rr_way + WAY_W'(1);
    end
  end
endmodule

// File: rtl/mcache_ctrl.sv
module mcache_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int SETS       = 32,
  parameter int WAYS       = 4,
  parameter int WORD_W     = 32,
  parameter int CNT_W      = 16,
  localparam int OFFS_W = $clog2(LINE_BYTES),
  localparam int IDX_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int TAG_W  = ADDR_W - OFFS_W - IDX_W,
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int WORDS  = LINE_W / WORD_W,
  localparam int WSEL_W = $clog2(WORDS),
  localparam int BYTE_W = $clog2(WORD_W / 8)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              resp_valid,
  output logic [WORD_W-1:0] resp_data,
  output logic              refill_req_valid,
  output logic [ADDR_W-1:0] refill_addr,
  input  logic              refill_valid,
  input  logic [LINE_W-1:0] refill_line,
  output logic [CNT_W-1:0]  cnt_major_hit,
  output logic [CNT_W-1:0]  cnt_other_hit,
  output logic [CNT_W-1:0]  cnt_miss
);
  import mcache_pkg::*;

  mc_state_e         state_q;
  logic [TAG_W-1:0]  tag_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WSEL_W-1:0] wsel_q;
  logic [WAY_W-1:0]  sel_way_q;

  // incoming address fields
  logic [TAG_W-1:0]  in_tag;
  logic [IDX_W-1:0]  in_idx;
  logic [WAY_W-1:0]  in_home;
  logic [WAY_W-1:0]  home_q;
  assign in_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign in_idx  = req_addr[OFFS_W +: IDX_W];
  assign in_home = in_tag[WAY_W-1:0];
  assign home_q  = tag_q[WAY_W-1:0];

  logic accept;
  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  // tag lookup
  logic [IDX_W-1:0]           lk_idx;
  logic [TAG_W-1:0]           cmp_tag;
  logic [WAYS-1:0][TAG_W-1:0] lk_tag;
  logic [WAYS-1:0]            lk_vld;
  logic [WAYS-1:0]            hit_vec;
  logic                       hit_any;
  logic [WAY_W-1:0]           hit_way;

  assign lk_idx  = (state_q == ST_IDLE) ? in_idx : idx_q;
  assign cmp_tag = (state_q == ST_IDLE) ? in_tag : tag_q;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = lk_vld[w] && (lk_tag[w] == cmp_tag);
  end

  always_comb begin
    hit_any = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) begin
        hit_any = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
  end

  logic home_hit;
  assign home_hit = hit_vec[in_home];

  // fill and relocation
  logic             install;
  logic             relocate;
  logic [WAY_W-1:0] victim;
  assign install  = (state_q == ST_WAIT) && refill_valid;
  assign relocate = install && lk_vld[home_q];

  logic [WAYS-1:0]             ram_rd;
  logic [WAYS-1:0]             ram_we;
  logic [WAYS-1:0][LINE_W-1:0] ram_wdata;
  logic [WAYS-1:0][LINE_W-1:0] ram_line;
  logic [WAYS-1:0][TAG_W-1:0]  ts_wtag;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    localparam logic [WAY_W-1:0] WID = WAY_W'(w);
    assign ram_rd[w] = (accept && (in_home == WID))
                    || ((state_q == ST_SEARCH) && hit_any && (hit_way == WID))
                    || ((state_q == ST_FILL) && (home_q == WID));
    assign ram_we[w]    = install && ((home_q == WID) || (relocate && (victim == WID)));
    assign ram_wdata[w] = (home_q == WID) ? refill_line : ram_line[home_q];
    assign ts_wtag[w]   = (home_q == WID) ? tag_q : lk_tag[home_q];

    mcache_way_ram #(.SETS(SETS), .LINE_W(LINE_W)) u_ram (
      .clk     (clk),
      .rd_en   (ram_rd[w]),
      .rd_idx  (lk_idx),
      .wr_en   (ram_we[w]),
      .wr_idx  (idx_q),
      .wr_line (ram_wdata[w]),
      .rd_line (ram_line[w])
    );
  end

  mcache_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk    (clk),
    .rst    (rst),
    .lk_idx (lk_idx),
    .lk_tag (lk_tag),
    .lk_vld (lk_vld),
    .wr_idx (idx_q),
    .wr_en  (ram_we),
    .wr_tag (ts_wtag)
  );

  mcache_victim_sel #(.WAYS(WAYS), .SETS(SETS)) u_victim (
    .clk     (clk),
    .rst     (rst),
    .idx     (idx_q),
    .home    (home_q),
    .vld     (lk_vld),
    .advance (relocate),
    .victim  (victim)
  );

  assign resp_data = ram_line[sel_way_q][wsel_q*WORD_W +: WORD_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q          <= ST_IDLE;
      tag_q            <= '0;
      idx_q            <= '0;
      wsel_q           <= '0;
      sel_way_q        <= '0;
      resp_valid       <= 1'b0;
      refill_req_valid <= 1'b0;
      refill_addr      <= '0;
      cnt_major_hit    <= '0;
      cnt_other_hit    <= '0;
      cnt_miss         <= '0;
    end else begin
      resp_valid       <= 1'b0;
      refill_req_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            tag_q     <= in_tag;
            idx_q     <= in_idx;
            wsel_q    <= req_addr[BYTE_W +: WSEL_W];
            sel_way_q <= in_home;
            if (home_hit) begin
              resp_valid    <= 1'b1;
              cnt_major_hit <= cnt_major_hit + CNT_W'(1);
            end else begin
              state_q <= ST_SEARCH;
            end
          end
        end
        ST_SEARCH: begin
          if (hit_any) begin
            sel_way_q     <= hit_way;
            resp_valid    <= 1'b1;
            cnt_other_hit <= cnt_other_hit + CNT_W'(1);
            state_q       <= ST_IDLE;
          end else begin
            refill_req_valid <= 1'b1;
            refill_addr      <= {tag_q, idx_q, {OFFS_W{1'b0}}};
            cnt_miss         <= cnt_miss + CNT_W'(1);
            state_q          <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (refill_valid) state_q <= ST_FILL;
        end
        ST_FILL: begin
          resp_valid <= 1'b1;
          sel_way_q  <= home_q;
          state_q    <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mcache_ctrl_chk.sv
module mcache_ctrl_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             resp_valid,
  input logic             refill_req_valid,
  input logic [CNT_W-1:0] cnt_major_hit,
  input logic [CNT_W-1:0] cnt_other_hit,
  input logic [CNT_W-1:0] cnt_miss
);
  AST_REFILL_PULSE: assert property (@(posedge clk) disable iff (rst)
    refill_req_valid |=> !refill_req_valid); // R4

  AST_BUSY_ON_REFILL: assert property (@(posedge clk) disable iff (rst)
    refill_req_valid |-> !req_ready); // R9

  AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (resp_valid || !req_ready)); // R2

  AST_HOME_COUNTED: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && $past(req_valid && req_ready)) |-> (cnt_major_hit == $past(cnt_major_hit) + CNT_W'(1))); // R2

  AST_MISS_COUNTED: assert property (@(posedge clk) disable iff (rst)
    refill_req_valid |-> (cnt_miss == $past(cnt_miss) + CNT_W'(1))); // R10

  AST_OTHER_STEP: assert property (@(posedge clk) disable iff (rst)
    (cnt_other_hit == $past(cnt_other_hit)) || (cnt_other_hit == $past(cnt_other_hit) + CNT_W'(1))); // R10

  AST_RESP_NOT_WITH_REFILL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({resp_valid, refill_req_valid})); // R4
endmodule

bind mcache_ctrl mcache_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk              (clk),
  .rst              (rst),
  .req_valid        (req_valid),
  .req_ready        (req_ready),
  .resp_valid       (resp_valid),
  .refill_req_valid (refill_req_valid),
  .cnt_major_hit    (cnt_major_hit),
  .cnt_other_hit    (cnt_other_hit),
  .cnt_miss         (cnt_miss)
);

// File: tb/sim_mcache_ctrl.sv
`timescale 1ns/1ps
module sim_mcache_ctrl;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic [31:0]  req_addr = '0;
  logic         req_ready;
  logic         resp_valid;
  logic [31:0]  resp_data;
  logic         refill_req_valid;
  logic [31:0]  refill_addr;
  logic         refill_valid = 1'b0;
  logic [511:0] refill_line = '0;
  logic [15:0]  cnt_major_hit, cnt_other_hit, cnt_miss;

  int n_chk = 0;
  int n_bad = 0;
  int exp_major = 0, exp_other = 0, exp_miss = 0;
  logic [31:0] last_fill = '0;

  always #10 clk = ~clk;

  mcache_ctrl u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_data(resp_data),
    .refill_req_valid(refill_req_valid), .refill_addr(refill_addr),
    .refill_valid(refill_valid), .refill_line(refill_line),
    .cnt_major_hit(cnt_major_hit), .cnt_other_hit(cnt_other_hit), .cnt_miss(cnt_miss)
  );

  function automatic logic [31:0] mw(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h5A5A_0000;
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // memory model: answers each line request three cycles later
  initial begin
    forever begin
      @(negedge clk);
      if (refill_req_valid) begin
        last_fill = refill_addr;
        @(negedge clk);
        chk("R4 refill request lasts one cycle", {31'd0, refill_req_valid}, 32'd0);
        @(negedge clk);
        @(negedge clk);
        for (int w = 0; w < 16; w++)
          refill_line[w*32 +: 32] = mw({last_fill[31:6], w[3:0], 2'b00});
        refill_valid = 1'b1;
        @(negedge clk);
        refill_valid = 1'b0;
      end
    end
  end

  // one read; called at a negedge with req_ready high
  task automatic expect_access(input logic [31:0] a, input int exp_lat, input string r);
    int lat;
    logic busy_ok;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    busy_ok = 1'b1;
    while (!resp_valid && lat < 40) begin
      if (req_ready) busy_ok = 1'b0;
      @(negedge clk);
      lat++;
    end
    chk({r, " latency"}, lat, exp_lat);
    chk({r, " data"}, resp_data, mw(a));
    if (exp_lat > 1) chk("R9 ready low while busy", {31'd0, busy_ok}, 32'd1);
    if (exp_lat == 1) exp_major++;
    else if (exp_lat == 2) exp_other++;
    else exp_miss++;
  endtask

  localparam logic [31:0] A = 32'h0000_20C4, B = 32'h0000_40C8, C = 32'h0000_60CC;
  localparam logic [31:0] D = 32'h0000_80D0, E = 32'h0000_A0D4, F = 32'h0001_11C8;

  task automatic t_reset;
    chk("R1 ready after reset", {31'd0, req_ready}, 32'd1);
    chk("R1 no response after reset", {31'd0, resp_valid}, 32'd0);
    chk("R1 no refill after reset", {31'd0, refill_req_valid}, 32'd0);
    chk("R1 counters zero", {cnt_major_hit, cnt_other_hit} | {16'd0, cnt_miss}, 32'd0);
  endtask

  task automatic t_cold_and_home;
    expect_access(A, 7, "R1 R4 R5 cold miss");
    chk("R4 refill address", last_fill, 32'h0000_20C0);
    expect_access(32'h0000_20F8, 1, "R2 R5 home hit other word");
    expect_access(32'h0000_20C0, 1, "R2 back-to-back home hit");
  endtask

  task automatic t_relocate;
    expect_access(B, 7, "R5 miss same home way");
    expect_access(A, 2, "R3 R6 moved line hits elsewhere");
    expect_access(B, 1, "R2 new line in home way");
  endtask

  task automatic t_fill_set;
    expect_access(C, 7, "R7 miss fills free way");
    expect_access(D, 7, "R7 miss fills last free way");
    expect_access(E, 7, "R8 miss in full set");
    expect_access(A, 7, "R8 pointer way dropped");
    expect_access(C, 2, "R7 R3 line kept in way 3");
    expect_access(D, 2, "R8 moved line kept");
    expect_access(E, 2, "R8 moved line kept second");
    expect_access(B, 7, "R8 second pointer way dropped");
    expect_access(A, 2, "R8 moved line after third drop");
  endtask

  task automatic t_other_set;
    expect_access(F, 7, "R11 miss in other set home way 2");
    chk("R11 refill address", last_fill, 32'h0001_11C0);
    expect_access(F, 1, "R11 home way 2 hit");
    expect_access(D, 2, "R11 first set untouched");
  endtask

  task automatic t_counters;
    chk("R10 home hit count", {16'd0, cnt_major_hit}, exp_major);
    chk("R10 other hit count", {16'd0, cnt_other_hit}, exp_other);
    chk("R10 miss count", {16'd0, cnt_miss}, exp_miss);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_cold_and_home();
    t_relocate();
    t_fill_set();
    t_other_set();
    t_counters();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule